// File: doc/BRIEF.md
# ADC Sample Pacer and Conversion Control

This block sequences an external analog-to-digital converter for a voice signal processor. A free-running down-counter divides the 20.48 MHz core clock into one of two sample rates, 16 kHz or 8 kHz. Each time the counter expires, it sends a one-clock interrupt request to the processor. A small register port lets the processor set the converter controls: an enable, a rate choice and a launch bit. Through the same port the processor reads a completion flag and the latest sample.

Conversions run in one of two ways. If the processor writes 1 to the launch bit, exactly one conversion starts straight away. If the launch bit holds 0, every timer expiry starts a conversion. The converter is outside this block and is reached by a handshake. The block sends a one-clock start pulse and waits for a one-clock done pulse that comes with the sample. Reading the sample register clears the completion flag. A spare control bit drives a general-purpose output pin directly.

Top module: `adcp_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0x04, status (address 1) reads 0x00 and data (address 2) reads 0x00. `sampleIrq`, `convStart` and `gpOut` are low.
- R2: Control bit 1 is the enable and reads back as written. While it is 0, neither a launch write nor a timer expiry produces `convStart`. The value written in a control write governs a launch requested in that same write.
- R3: A control write with bit 2 (launch) set and enable set, while idle, gives exactly one `convStart` pulse in the cycle after the write edge. Bit 2 then reads back as 1.
- R4: While bit 2 holds 0 and enable is 1, each `sampleIrq` pulse is followed in the next cycle by a `convStart` pulse, provided no conversion is outstanding.
- R5: Control bit 0 selects the sample period: 1 gives 1280 clocks (16 kHz) and 0 gives 2560 clocks (8 kHz), measured from one `sampleIrq` pulse to the next.
- R6: A rate change takes effect at the next counter reload. The period already in progress keeps its old length.
- R7: `sampleIrq` is high for exactly one clock per expiry, whatever the enable setting.
- R8: A `convDone` pulse during an outstanding conversion stores `convData` and sets status bit 0. A read of address 2 returns the stored sample and clears status bit 0.
- R9: Launch requests are ignored while a conversion is outstanding. A `convDone` pulse with no conversion outstanding changes neither the stored sample nor status bit 0.
- R10: `gpOut` follows control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20.48 MHz core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read of address 2 clears done flag) |
| regAddr | input | 2 | Register address: 0 control, 1 status, 2 data |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from address |
| convData | input | DATA_W | Sample from converter, valid with convDone |
| convDone | input | 1 | One-clock conversion complete pulse |
| convStart | output | 1 | One-clock conversion start pulse |
| sampleIrq | output | 1 | One-clock timer expiry interrupt request |
| gpOut | output | 1 | General-purpose output pin |

## Verification
The timer is measured as stamped intervals between interrupt pulses at both rates. A rate change written in mid-period shows whether the reload is deferred or the count is cut short. Conversions are driven three ways: by launch writes, by timer pacing and with the unit disabled. This separates the two start sources and the enable gate. A second launch sent while a conversion is still outstanding, and done pulses that arrive when nothing is pending, show whether the busy guard blocks them. Reading status before and after the data read confirms that the done flag clears as a side effect of the read.

// File: rtl/adcp_pkg.sv
package adcp_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } regAddrE;

  localparam int CTRL_RATE  = 0;
  localparam int CTRL_EN    = 1;
  localparam int CTRL_START = 2;
  localparam int CTRL_GP    = 7;
  localparam int STAT_DONE  = 0;

  typedef struct packed {
    logic rateFast;
    logic capture;
  } dpStrobeT;
endpackage

// File: rtl/adcp_datapath.sv
module adcp_datapath
  import adcp_pkg::*;
#(
  parameter int FAST_DIV = 1280,
  parameter int SLOW_DIV = 2560,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [DATA_W-1:0] convData,
  output logic              tick,
  output logic [DATA_W-1:0] sampleData
);
  localparam int CNT_W = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reloadVal;

  assign tick      = (cnt == '0);
  assign reloadVal = strobe.rateFast ? FAST_LOAD : SLOW_LOAD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= SLOW_LOAD;
    else if (tick) cnt <= reloadVal;
    else           cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sampleData <= '0;
    else if (strobe.capture) sampleData <= convData;
  end

  // R7: expiry is a single-clock pulse
  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R5: between reloads the counter steps down by one
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> (cnt == $past(cnt) - 1'b1));

  // R6: reload picks the period selected at the expiry edge
  assert_reload_fast_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && strobe.rateFast) |=> (cnt == FAST_LOAD));
  assert_reload_slow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.rateFast) |=> (cnt == SLOW_LOAD));
endmodule

// File: rtl/adcp_ctrl.sv
module adcp_ctrl
  import adcp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              tick,
  input  logic              convDone,
  output logic              convStart,
  output dpStrobeT          strobe,
  output logic              gpOut
);
  logic rateFast, enable, startBit, gpBit, busy, doneFlag;
  logic ctrlWr, dataRd, enNext, singleReq, pacedReq, accept, capture;

  assign ctrlWr    = regWrEn && (regAddr == ADDR_CTRL);
  assign dataRd    = regRdEn && (regAddr == ADDR_DATA);
  assign enNext    = ctrlWr ? regWrData[CTRL_EN] : enable;
  assign singleReq = ctrlWr && regWrData[CTRL_START];
  assign pacedReq  = tick && !startBit;
  assign accept    = enNext && !busy && (singleReq || pacedReq);
  assign capture   = busy && convDone;

  assign strobe.rateFast = rateFast;
  assign strobe.capture  = capture;
  assign gpOut           = gpBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateFast <= 1'b0;
      enable   <= 1'b0;
      startBit <= 1'b1;
      gpBit    <= 1'b0;
    end else if (ctrlWr) begin
      rateFast <= regWrData[CTRL_RATE];
      enable   <= regWrData[CTRL_EN];
      startBit <= regWrData[CTRL_START];
      gpBit    <= regWrData[CTRL_GP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      convStart <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      convStart <= accept;
      if (!enNext)     busy <= 1'b0;
      else if (accept) busy <= 1'b1;
      else if (capture) busy <= 1'b0;
      if (capture)     doneFlag <= 1'b1;
      else if (dataRd) doneFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdData[CTRL_RATE]  = rateFast;
        regRdData[CTRL_EN]    = enable;
        regRdData[CTRL_START] = startBit;
        regRdData[CTRL_GP]    = gpBit;
      end
      ADDR_STAT: regRdData[STAT_DONE] = doneFlag;
      ADDR_DATA: regRdData = REG_W'(sampleData);
      default:   regRdData = '0;
    endcase
  end

  // R2: a start only leaves while the unit is enabled
  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> enable);

  // R9: an outstanding conversion blocks the next launch
  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R4: timer-paced launch follows an expiry
  assert_paced_launch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !startBit && enable && !busy && !regWrEn) |=> convStart);

  // R8: completion sets the flag, data read clears it
  assert_done_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> doneFlag);
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !capture) |=> !doneFlag);
endmodule

// File: rtl/adcp_top.sv
module adcp_top
  import adcp_pkg::*;
#(
  parameter int FAST_DIV = 1280,
  parameter int SLOW_DIV = 2560,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [DATA_W-1:0] convData,
  input  logic              convDone,
  output logic              convStart,
  output logic              sampleIrq,
  output logic              gpOut
);
  dpStrobeT          strobe;
  logic              tick;
  logic [DATA_W-1:0] sampleData;

  assign sampleIrq = tick;

  adcp_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .sampleData(sampleData), .tick(tick), .convDone(convDone),
    .convStart(convStart), .strobe(strobe), .gpOut(gpOut)
  );

  adcp_datapath #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .convData(convData), .tick(tick), .sampleData(sampleData)
  );
endmodule

// File: tb/test_adcp_top.sv
module test_adcp_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0, regRdData;
  logic [7:0] convData = 8'd0;
  logic       convDone = 1'b0;
  logic       convStart, sampleIrq, gpOut;

  int checks = 0, errors = 0, cyc = 0, startCnt = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (convStart) startCnt <= startCnt + 1;
  end

  adcp_top i_adcp_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .convData(convData), .convDone(convDone), .convStart(convStart),
    .sampleIrq(sampleIrq), .gpOut(gpOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic waitIrq(output int stamp);
    do @(negedge clk); while (!sampleIrq);
    stamp = cyc;
  endtask

  task automatic pulseDone(input logic [7:0] d);
    @(negedge clk); convDone = 1'b1; convData = d;
    @(negedge clk); convDone = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 irq", sampleIrq, 0);
    check("R1 convStart", convStart, 0);
    check("R1 gpOut", gpOut, 0);
    regRead(2'd0, v); check("R1 ctrl", v, 8'h04);
    regRead(2'd1, v); check("R1 status", v, 0);
    regRead(2'd2, v); check("R1 data", v, 0);
  endtask

  task automatic testTimer();
    int t0, t1, t2, t3, t4, t5, s0;
    s0 = startCnt;
    waitIrq(t0);
    @(negedge clk); check("R7 irq width", sampleIrq, 0);
    waitIrq(t1); check("R5 slow period", t1 - t0, 2560);
    repeat (100) @(negedge clk);
    regWrite(2'd0, 8'h05);
    waitIrq(t2); check("R6 period in progress kept", t2 - t1, 2560);
    waitIrq(t3); check("R5 fast period", t3 - t2, 1280);
    repeat (200) @(negedge clk);
    regWrite(2'd0, 8'h04);
    waitIrq(t4); check("R6 fast period kept", t4 - t3, 1280);
    waitIrq(t5); check("R6 slow after reload", t5 - t4, 2560);
    check("R7 irq with enable off starts nothing", startCnt - s0, 0);
  endtask

  task automatic testSingle();
    logic [7:0] v;
    int s0;
    s0 = startCnt;
    regWrite(2'd0, 8'h06);
    check("R3 start pulse", convStart, 1);
    @(negedge clk); check("R3 start ends", convStart, 0);
    check("R3 one pulse", startCnt - s0, 1);
    regRead(2'd0, v); check("R3 launch bit reads 1", v, 8'h06);
    regRead(2'd1, v); check("R8 status before done", v, 0);
    regWrite(2'd0, 8'h06);
    @(negedge clk); check("R9 launch while busy ignored", startCnt - s0, 1);
    pulseDone(8'hA5);
    regRead(2'd1, v); check("R8 done flag set", v, 1);
    regRead(2'd2, v); check("R8 data captured", v, 8'hA5);
    regRead(2'd1, v); check("R8 flag cleared by read", v, 0);
    pulseDone(8'h3C);
    regRead(2'd1, v); check("R9 stray done no flag", v, 0);
    regRead(2'd2, v); check("R9 stray done no data", v, 8'hA5);
  endtask

  task automatic testPaced();
    logic [7:0] v;
    int t, s0;
    regWrite(2'd0, 8'h02);
    s0 = startCnt;
    waitIrq(t);
    @(negedge clk); check("R4 paced start", convStart, 1);
    repeat (5) @(negedge clk);
    pulseDone(8'h11);
    regRead(2'd2, v); check("R4 paced data", v, 8'h11);
    waitIrq(t);
    @(negedge clk); check("R4 second paced start", convStart, 1);
    waitIrq(t);
    @(negedge clk); check("R9 expiry while busy ignored", convStart, 0);
    check("R4 start count", startCnt - s0, 2);
    pulseDone(8'h22);
    regRead(2'd2, v); check("R8 paced data", v, 8'h22);
  endtask

  task automatic testDisable();
    logic [7:0] v;
    int t, s0;
    regWrite(2'd0, 8'h00);
    regRead(2'd0, v); check("R2 enable reads 0", v, 0);
    s0 = startCnt;
    waitIrq(t);
    @(negedge clk); check("R2 no paced start when off", convStart, 0);
    regWrite(2'd0, 8'h04);
    check("R2 no launch when off", convStart, 0);
    @(negedge clk); check("R2 start count", startCnt - s0, 0);
  endtask

  task automatic testGp();
    logic [7:0] v;
    regWrite(2'd0, 8'h80);
    check("R10 gpOut high", gpOut, 1);
    regRead(2'd0, v); check("R10 ctrl readback", v, 8'h80);
    regWrite(2'd0, 8'h00);
    check("R10 gpOut low", gpOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTimer();
    testSingle();
    testPaced();
    testDisable();
    testGp();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule